// File: doc/BRIEF.md
# Commutation-Synchronized Output Control Shadow Bank

This block keeps two copies of the output control word for each channel of a multi-channel timer. Each word holds an output enable bit, a complementary output enable bit and a 3-bit compare mode. Software writes always land in a staged (shadow) copy. The copy that drives the output stages (the active copy) is updated in one of two ways, depending on a staging switch. With staging off, a write reaches the active copy directly. With staging on, the active copy changes only when a commutation event occurs. At that event every channel that has a complementary output takes its staged word at the same clock edge. This lets a motor-drive sequence reconfigure several phases atomically.

A commutation event has two possible sources. One is a one-cycle software strobe. The other is a rising edge on an external trigger line, and a source-select bit decides whether that edge counts. The edge is detected by holding the previous sample of the trigger input in a register and comparing it with the current value. Channels built without a complementary output ignore the staging switch and always update directly. Which channels have a complementary output is fixed by a parameter mask.

Top module: `ctrl_shadow_bank`

## Requirements
- R1: After reset, every active output bit is 0 and every staged word is 0. A commutation event with no prior write therefore leaves all outputs at 0.
- R2: With `stageEn`=0, writing channel c (`wrStb[c]`=1) makes that channel's active word equal to the written data from the next clock edge on.
- R3: With `stageEn`=1 and no commutation event, a write to a channel whose `cmplMask` bit is 1 leaves its active word unchanged.
- R4: With `stageEn`=1, a `swCommute` pulse copies the staged word into the active word of every complementary channel at the same edge.
- R5: With `trigSrcSel`=0, a rising edge on `trigIn` causes no commutation.
- R6: With `trigSrcSel`=1, a 0-to-1 change of `trigIn` between two consecutive clock samples commutes. A `trigIn` that stays high, or that falls, does not commute.
- R7: A channel whose `cmplMask` bit is 0 updates its active word on every write, whatever the value of `stageEn`.
- R8: When a write to a complementary channel and a commutation event fall in the same cycle with `stageEn`=1, the active word takes the newly written value.
- R9: Field layout: for channel c, the enables are bit c of `wrOutEn`/`actOutEn` and of `wrCmpEn`/`actCmpEn`, and the mode is bits [3c+2:3c] of `wrMode`/`actMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | NUM_CH | Per-channel write strobe |
| wrOutEn | input | NUM_CH | Written output enable per channel |
| wrCmpEn | input | NUM_CH | Written complementary output enable per channel |
| wrMode | input | 3*NUM_CH | Written compare mode, 3 bits per channel |
| stageEn | input | 1 | 1: complementary channels wait for a commutation event |
| trigSrcSel | input | 1 | 1: trigger rising edge also commutes |
| swCommute | input | 1 | One-cycle software commutation strobe |
| trigIn | input | 1 | External trigger line |
| actOutEn | output | NUM_CH | Active output enable per channel |
| actCmpEn | output | NUM_CH | Active complementary output enable per channel |
| actMode | output | 3*NUM_CH | Active compare mode, 3 bits per channel |

## Verification
The hardest case to reach is a trigger-driven commutation that coincides with writes to some channels but not others. That single edge must merge fresh data and staged data across channels, and it depends on the trigger's previous sample. A long pseudo-random sweep reaches it by toggling the trigger line, the source select, the staging switch and the per-channel strobes independently every cycle. A bench model that tracks its own previous trigger sample predicts every channel's word after every edge. Directed sequences before the sweep pin down the held-high trigger, the disabled trigger source and the same-cycle write-plus-commute cases.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int MODE_W = 3;
  localparam int WORD_W = MODE_W + 2;

  typedef struct packed {
    logic outEn;
    logic cmpEn;
    logic [MODE_W-1:0] mode;
  } ctlWord_t;

  typedef struct packed {
    logic shadowLd;
    logic activeLd;
    logic activeFromWr;
  } chStrobe_t;
endpackage

// File: rtl/cmt_ctrl.sv
module cmt_ctrl #(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] CMPL_MASK = '1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_CH-1:0] wrStb,
  input  logic stageEn,
  input  logic trigSrcSel,
  input  logic swCommute,
  input  logic trigIn,
  output cmt_pkg::chStrobe_t [NUM_CH-1:0] strobes
);
  logic trigPrev;
  logic trigRise;
  logic commEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigIn;
  end

  assign trigRise  = trigIn & ~trigPrev;
  assign commEvent = swCommute | (trigSrcSel & trigRise);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (CMPL_MASK[c]) begin : g_staged
      always_comb begin
        strobes[c].shadowLd = wrStb[c];
        if (stageEn) begin
          strobes[c].activeLd     = commEvent;
          strobes[c].activeFromWr = wrStb[c];
        end else begin
          strobes[c].activeLd     = wrStb[c];
          strobes[c].activeFromWr = 1'b1;
        end
      end
    end else begin : g_direct
      always_comb begin
        strobes[c].shadowLd     = wrStb[c];
        strobes[c].activeLd     = wrStb[c];
        strobes[c].activeFromWr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmt_datapath.sv
module cmt_datapath #(
  parameter int NUM_CH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  cmt_pkg::chStrobe_t [NUM_CH-1:0] strobes,
  input  cmt_pkg::ctlWord_t  [NUM_CH-1:0] wrWord,
  output cmt_pkg::ctlWord_t  [NUM_CH-1:0] activeWord
);
  cmt_pkg::ctlWord_t [NUM_CH-1:0] shadowWord;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmt_pkg::ctlWord_t nextActive;

    assign nextActive = strobes[c].activeFromWr ? wrWord[c] : shadowWord[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowWord[c] <= '0;
      end else if (strobes[c].shadowLd) begin
        shadowWord[c] <= wrWord[c];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activeWord[c] <= '0;
      end else if (strobes[c].activeLd) begin
        activeWord[c] <= nextActive;
      end
    end
  end
endmodule

// File: rtl/ctrl_shadow_bank.sv
module ctrl_shadow_bank #(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] CMPL_MASK = 4'b0111
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_CH-1:0] wrStb,
  input  logic [NUM_CH-1:0] wrOutEn,
  input  logic [NUM_CH-1:0] wrCmpEn,
  input  logic [cmt_pkg::MODE_W*NUM_CH-1:0] wrMode,
  input  logic stageEn,
  input  logic trigSrcSel,
  input  logic swCommute,
  input  logic trigIn,
  output logic [NUM_CH-1:0] actOutEn,
  output logic [NUM_CH-1:0] actCmpEn,
  output logic [cmt_pkg::MODE_W*NUM_CH-1:0] actMode
);
  localparam int MW = cmt_pkg::MODE_W;

  cmt_pkg::chStrobe_t [NUM_CH-1:0] strobes;
  cmt_pkg::ctlWord_t  [NUM_CH-1:0] wrWord;
  cmt_pkg::ctlWord_t  [NUM_CH-1:0] activeWord;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    assign wrWord[c].outEn = wrOutEn[c];
    assign wrWord[c].cmpEn = wrCmpEn[c];
    assign wrWord[c].mode  = wrMode[MW*c +: MW];
    assign actOutEn[c]        = activeWord[c].outEn;
    assign actCmpEn[c]        = activeWord[c].cmpEn;
    assign actMode[MW*c +: MW] = activeWord[c].mode;
  end

  cmt_ctrl #(.NUM_CH(NUM_CH), .CMPL_MASK(CMPL_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .stageEn(stageEn),
    .trigSrcSel(trigSrcSel), .swCommute(swCommute), .trigIn(trigIn),
    .strobes(strobes)
  );

  cmt_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrWord(wrWord),
    .activeWord(activeWord)
  );
endmodule

// File: rtl/cmt_chk.sv
module cmt_chk #(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] CMPL_MASK = 4'b0111
) (
  input logic clk,
  input logic rstN,
  input logic [NUM_CH-1:0] wrStb,
  input logic [NUM_CH-1:0] wrOutEn,
  input logic [NUM_CH-1:0] wrCmpEn,
  input logic [3*NUM_CH-1:0] wrMode,
  input logic stageEn,
  input logic trigSrcSel,
  input logic swCommute,
  input logic trigIn,
  input logic [NUM_CH-1:0] actOutEn,
  input logic [NUM_CH-1:0] actCmpEn,
  input logic [3*NUM_CH-1:0] actMode
);
  logic seenTrig;
  logic anyEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenTrig <= 1'b0;
    else       seenTrig <= trigIn;
  end

  assign anyEvent = swCommute | (trigSrcSel & trigIn & ~seenTrig);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (CMPL_MASK[c]) begin : g_staged
      // R2
      r2_direct_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!stageEn && wrStb[c]) |=>
          ({actOutEn[c], actCmpEn[c], actMode[3*c +: 3]} ==
           $past({wrOutEn[c], wrCmpEn[c], wrMode[3*c +: 3]})));
      // R3
      r3_hold_without_event_chk: assert property (@(posedge clk) disable iff (!rstN)
        (stageEn && !anyEvent) |=>
          $stable({actOutEn[c], actCmpEn[c], actMode[3*c +: 3]}));
      // R8
      r8_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        (stageEn && anyEvent && wrStb[c]) |=>
          ({actOutEn[c], actCmpEn[c], actMode[3*c +: 3]} ==
           $past({wrOutEn[c], wrCmpEn[c], wrMode[3*c +: 3]})));
    end else begin : g_direct
      // R7
      r7_unstaged_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        wrStb[c] |=>
          ({actOutEn[c], actCmpEn[c], actMode[3*c +: 3]} ==
           $past({wrOutEn[c], wrCmpEn[c], wrMode[3*c +: 3]})));
    end
    // R1
    r1_idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!wrStb[c] && !anyEvent) |=>
        $stable({actOutEn[c], actCmpEn[c], actMode[3*c +: 3]}));
  end
endmodule

bind ctrl_shadow_bank cmt_chk #(.NUM_CH(NUM_CH), .CMPL_MASK(CMPL_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrOutEn(wrOutEn), .wrCmpEn(wrCmpEn),
  .wrMode(wrMode), .stageEn(stageEn), .trigSrcSel(trigSrcSel),
  .swCommute(swCommute), .trigIn(trigIn), .actOutEn(actOutEn),
  .actCmpEn(actCmpEn), .actMode(actMode)
);

// File: tb/tb_ctrl_shadow_bank.sv
module tb_ctrl_shadow_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam logic [NCH-1:0] MASK = 4'b0111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] wrStb = '0, wrOutEn = '0, wrCmpEn = '0;
  logic [3*NCH-1:0] wrMode = '0;
  logic stageEn = 1'b0, trigSrcSel = 1'b0, swCommute = 1'b0, trigIn = 1'b0;
  logic [NCH-1:0] actOutEn, actCmpEn;
  logic [3*NCH-1:0] actMode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [4:0] mSh [NCH];
  logic [4:0] mAct [NCH];
  logic mTrigPrev = 1'b0;
  string tags [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_shadow_bank #(.NUM_CH(NCH), .CMPL_MASK(MASK)) dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrOutEn(wrOutEn), .wrCmpEn(wrCmpEn),
    .wrMode(wrMode), .stageEn(stageEn), .trigSrcSel(trigSrcSel),
    .swCommute(swCommute), .trigIn(trigIn), .actOutEn(actOutEn),
    .actCmpEn(actCmpEn), .actMode(actMode)
  );

  function automatic logic [4:0] dutWord(int c);
    return {actOutEn[c], actCmpEn[c], actMode[3*c +: 3]};
  endfunction

  task automatic check(string tag, int c, logic [4:0] exp);
    total++;
    if (dutWord(c) !== exp) begin
      bad++;
      $display("FAIL %s ch%0d actual=%h expected=%h", tag, c, dutWord(c), exp);
    end
  endtask

  // One cycle: drive after a falling edge, model at the rising edge, compare at the next falling edge.
  task automatic apply(logic [NCH-1:0] s, logic [NCH-1:0] oe, logic [NCH-1:0] ce,
                       logic [3*NCH-1:0] md, logic pre, logic sel, logic sw, logic trg);
    logic ev;
    logic trgRise;
    wrStb = s; wrOutEn = oe; wrCmpEn = ce; wrMode = md;
    stageEn = pre; trigSrcSel = sel; swCommute = sw; trigIn = trg;
    trgRise = trg & ~mTrigPrev;
    ev = sw | (sel & trgRise);
    for (int c = 0; c < NCH; c++) begin
      if (!MASK[c])            tags[c] = "R7";
      else if (!pre)           tags[c] = "R2";
      else if (ev && s[c])     tags[c] = "R8";
      else if (ev && !sw)      tags[c] = "R6";
      else if (ev)             tags[c] = "R4";
      else if (trgRise && !sel) tags[c] = "R5";
      else                     tags[c] = "R3";
    end
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      logic [4:0] w;
      w = {oe[c], ce[c], md[3*c +: 3]};
      if (!MASK[c] || !pre) begin
        if (s[c]) mAct[c] = w;
      end else if (ev) begin
        mAct[c] = s[c] ? w : mSh[c];
      end
      if (s[c]) mSh[c] = w;
    end
    mTrigPrev = trg;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check(tags[c], c, mAct[c]);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int c = 0; c < NCH; c++) begin mSh[c] = '0; mAct[c] = '0; end
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R1", c, 5'h00);
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R1", c, 5'h00);
    // R1: commutation with nothing staged keeps zeros
    apply('0, '0, '0, '0, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int c = 0; c < NCH; c++) check("R1", c, 5'h00);
    // R3 and R7: staged write, only the unstaged channel moves
    apply(4'hF, 4'hF, 4'hA, 12'h5A3, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5: trigger rise with source disabled
    apply('0, '0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
    apply('0, '0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: trigger held high gives no event, then a genuine rise commutes
    apply('0, '0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    trigIn = 1'b1;
    apply('0, '0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
    apply('0, '0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b1);
    apply('0, '0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    apply('0, '0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b1);
    // R4: restage and commute by software
    apply(4'h7, 4'h2, 4'h5, 12'hC71, 1'b1, 1'b0, 1'b0, 1'b0);
    apply('0, '0, '0, '0, 1'b1, 1'b0, 1'b1, 1'b0);
    // R8: write and commute in one cycle, channel 0 fresh, 1 and 2 from stage
    apply(4'h2, 4'h0, 4'h0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0);
    apply(4'h1, 4'h1, 4'h1, 12'h006, 1'b1, 1'b0, 1'b1, 1'b0);
    // R2 and R9: direct writes with distinct per-field patterns
    apply(4'hF, 4'h9, 4'h6, 12'h9C5, 1'b0, 1'b0, 1'b0, 1'b0);
    apply(4'h5, 4'h6, 4'h9, 12'h3A6, 1'b0, 1'b1, 1'b1, 1'b1);
    // sweep
    r = 32'h1D2C3B4A;
    for (int i = 0; i < 4000; i++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      apply(r[3:0], r[15:12], r[19:16], r[31:20], r[4] | r[5], r[6],
            r[7] & r[8] & r[9], r[11]);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule